// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block collects 32 interrupt sources and drives two processor interrupt lines: a normal request line and a fast request line. Each line has its own register bank. Both banks look at the same conditioned source vector. Each source first passes through a polarity stage, where it is either passed straight or inverted. It then passes through an optional sticky latch that holds an assertion until software acknowledges it.

Each source has a 4-bit priority, where a lower value means more urgent. Each bank has its own enable mask, a threshold and a selection of the next source to service. A source is eligible in a bank when it is pending, enabled in that bank, and its priority value is no greater than that bank's threshold. The winner is the eligible source with the lowest priority value, and ties go to the lowest source number. Software sets mask bits through one write-one register and clears them through another. Reading a bank's acknowledge register clears the sticky latch of that bank's current winner.

Access is through a synchronous register port. Read data returns one cycle after the request and is qualified by `rvalid_o`. The port is driven by a two-state machine. In PORT_IDLE no read data is outstanding. An accepted read moves it to PORT_RESP. It stays in PORT_RESP while back-to-back reads arrive and returns to PORT_IDLE on any cycle without a read.

Top module: `prio_intc`

## Requirements
- R1: After reset both masks are 0, both thresholds are 0xF, every priority is 0, the polarity select reads 0xFFFFFFFF, the sticky select reads 0, and `irq_o`, `fiq_o` and `rvalid_o` are low.
- R2: The normal bank sits at base 0x000 and the fast bank at 0x100. A write to bank offset 0x08 sets the mask bits that are 1 in the data. A write to offset 0x0C clears them. Zero bits leave the mask unchanged. Reading offset 0x08 returns the mask, and reading 0x0C returns 0.
- R3: Polarity select at 0x200: a 1 bit passes source i unchanged and a 0 bit inverts it. Bank offset 0x04 returns the conditioned vector before masking, and it is the same in both banks.
- R4: Sticky select at 0x204: with bit i = 0 the conditioned source follows its level. With bit i = 1 an assertion is held after the input drops.
- R5: Bank offset 0x00 returns the vector of pending, enabled, eligible sources of that bank.
- R6: Bank offsets 0x20 and 0x28 return, in bits [4:0], the number of the eligible source with the lowest priority value, with ties going to the lowest number. They return 0 when nothing is eligible.
- R7: The priority of source i is in bits [3:0] of the word at 0x300 + 4*i. The threshold is in bits [3:0] of bank offset 0x2C. A source is eligible only when its priority is at or below the threshold.
- R8: A read of bank offset 0x28 clears the sticky latch of that bank's current winner. It leaves the latches untouched when that bank has no eligible source.
- R9: `irq_o` / `fiq_o` is the registered OR of the bank's eligible vector and changes one clock after that vector.
- R10: The two banks are independent: a mask or threshold in one bank has no effect on the other bank's status, current source or line.
- R11: Read data appears with `rvalid_o` exactly one cycle after the read request. Writes to the read-only offsets 0x00, 0x04, 0x20 and 0x28 are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Raw interrupt source levels |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Normal-bank interrupt line |
| fiq_o | output | 1 | Fast-bank interrupt line |

## Verification
A write or a source change takes effect at the next clock edge. A read issued in the same cycle as that edge samples the new conditioned and eligible state, and its data comes back with `rvalid_o` one edge later. The interrupt lines lag the eligible vector by one more register. The driver changes inputs on falling edges and pushes each expected read value into a queue at request time. A monitor on the falling edge pops and compares whenever `rvalid_o` is high. Line checks are taken one falling edge after the stimulus edge plus one more cycle, so that the output register has been loaded.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_RAW   = 8'h04;
    localparam logic [7:0] OFS_SET   = 8'h08;
    localparam logic [7:0] OFS_CLR   = 8'h0C;
    localparam logic [7:0] OFS_CUR   = 8'h20;
    localparam logic [7:0] OFS_ACK   = 8'h28;
    localparam logic [7:0] OFS_THR   = 8'h2C;
    localparam logic [11:0] ADR_POL  = 12'h200;
    localparam logic [11:0] ADR_STK  = 12'h204;
    localparam logic [4:0]  PRIO_PAGE = 5'h06;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pol_sel_i,
    input  logic [N-1:0] stk_sel_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] cond_o
);
    logic [N-1:0] lvl;
    logic [N-1:0] held;

    // polarity: select bit 1 passes, 0 inverts
    assign lvl = src_i ^ ~pol_sel_i;

    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= ((held & ~ack_clr_i) | lvl) & stk_sel_i;
    end

    assign cond_o = lvl | held;

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((held & ~ack_clr_i) != '0) |=>
        ((held & $past(held & ~ack_clr_i) & stk_sel_i) == ($past(held & ~ack_clr_i) & stk_sel_i)));

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_clr_i & ~lvl) != '0) |=> ((held & $past(ack_clr_i & ~lvl)) == '0));
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [PW-1:0]        thr_i,
    output logic [N-1:0]         elig_o,
    output logic                 any_o,
    output logic [IW-1:0]        idx_o
);
    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig_o[i] = pend_i[i] && (prio_i[i] <= thr_i);
    end

    logic [PW-1:0] best;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (elig_o[i] && (!any_o || prio_i[i] < best)) begin
                any_o = 1'b1;
                idx_o = IW'(i);
                best  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cond_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic                 set_we_i,
    input  logic                 clr_we_i,
    input  logic                 thr_we_i,
    input  logic [N-1:0]         wbits_i,
    input  logic [PW-1:0]        wthr_i,
    output logic [N-1:0]         mask_o,
    output logic [PW-1:0]        thr_o,
    output logic [N-1:0]         elig_o,
    output logic                 any_o,
    output logic [IW-1:0]        cur_o,
    output logic                 line_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            thr_o  <= '1;
            line_o <= 1'b0;
        end else begin
            if (set_we_i)      mask_o <= mask_o | wbits_i;
            else if (clr_we_i) mask_o <= mask_o & ~wbits_i;
            if (thr_we_i)      thr_o  <= wthr_i;
            line_o <= any_o;
        end
    end

    intc_prio_pick #(.N(N), .PW(PW)) u_pick (
        .pend_i (cond_i & mask_o),
        .prio_i (prio_i),
        .thr_i  (thr_o),
        .elig_o (elig_o),
        .any_o  (any_o),
        .idx_o  (cur_o)
    );

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((mask_o & $past(wbits_i)) == $past(wbits_i)));

    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i) |=> ((mask_o & $past(wbits_i)) == '0));

    // R6
    cur_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> elig_o[cur_o]);

    // R9
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> $past(mask_o != '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [11:0] addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        rvalid_o,
    output logic        irq_o,
    output logic        fiq_o
);
    localparam int N  = 32;
    localparam int PW = 4;
    localparam int NB = 2;
    localparam int IW = $clog2(N);

    logic [N-1:0]          pol_sel, stk_sel, cond, ack_clr;
    logic [N-1:0][PW-1:0]  prio_q;
    logic [NB-1:0][N-1:0]  mask, elig;
    logic [NB-1:0][PW-1:0] thr;
    logic [NB-1:0][IW-1:0] cur;
    logic [NB-1:0]         any, line, set_we, clr_we, thr_we;

    logic       rd_fire, wr_fire, bank_hit, prio_hit;
    logic       bsel;
    logic [7:0] ofs;
    logic [IW-1:0] pidx;
    logic [31:0] rd_val;
    port_state_e state, state_nx;

    assign rd_fire  = req_i && !we_i;
    assign wr_fire  = req_i && we_i;
    assign bank_hit = (addr_i[11:9] == 3'b000);
    assign bsel     = addr_i[8];
    assign ofs      = addr_i[7:0];
    assign prio_hit = (addr_i[11:7] == PRIO_PAGE) && (addr_i[1:0] == 2'b00);
    assign pidx     = addr_i[2 +: IW];

    intc_src_cond #(.N(N)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .pol_sel_i (pol_sel),
        .stk_sel_i (stk_sel),
        .ack_clr_i (ack_clr),
        .cond_o    (cond)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit       = wr_fire && bank_hit && (bsel == b[0]);
        assign set_we[b] = hit && (ofs == OFS_SET);
        assign clr_we[b] = hit && (ofs == OFS_CLR);
        assign thr_we[b] = hit && (ofs == OFS_THR);

        intc_bank #(.N(N), .PW(PW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond_i   (cond),
            .prio_i   (prio_q),
            .set_we_i (set_we[b]),
            .clr_we_i (clr_we[b]),
            .thr_we_i (thr_we[b]),
            .wbits_i  (wdata_i[N-1:0]),
            .wthr_i   (wdata_i[PW-1:0]),
            .mask_o   (mask[b]),
            .thr_o    (thr[b]),
            .elig_o   (elig[b]),
            .any_o    (any[b]),
            .cur_o    (cur[b]),
            .line_o   (line[b])
        );
    end

    // acknowledge: clear held state of the reading bank's winner
    always_comb begin
        ack_clr = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_fire && bank_hit && (bsel == b[0]) && (ofs == OFS_ACK) && any[b])
                ack_clr[cur[b]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_sel <= '1;
            stk_sel <= '0;
            prio_q  <= '0;
        end else if (wr_fire) begin
            if (addr_i == ADR_POL) pol_sel <= wdata_i[N-1:0];
            if (addr_i == ADR_STK) stk_sel <= wdata_i[N-1:0];
            if (prio_hit)          prio_q[pidx] <= wdata_i[PW-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        if (bank_hit) begin
            case (ofs)
                OFS_PEND: rd_val[N-1:0]  = elig[bsel];
                OFS_RAW:  rd_val[N-1:0]  = cond;
                OFS_SET:  rd_val[N-1:0]  = mask[bsel];
                OFS_CUR,
                OFS_ACK:  rd_val[IW-1:0] = cur[bsel];
                OFS_THR:  rd_val[PW-1:0] = thr[bsel];
                default:  rd_val = '0;
            endcase
        end else if (addr_i == ADR_POL) begin
            rd_val[N-1:0] = pol_sel;
        end else if (addr_i == ADR_STK) begin
            rd_val[N-1:0] = stk_sel;
        end else if (prio_hit) begin
            rd_val[PW-1:0] = prio_q[pidx];
        end
    end

    // port state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PORT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PORT_IDLE: if (rd_fire)  state_nx = PORT_RESP;
            PORT_RESP: if (!rd_fire) state_nx = PORT_IDLE;
        endcase
    end

    // port outputs
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_fire) rdata_o <= rd_val;
    end

    assign rvalid_o = (state == PORT_RESP);
    assign irq_o    = line[0];
    assign fiq_o    = line[1];

    // R11
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rvalid_o);

    // R11
    rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(rd_fire));

    // R10
    fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(mask[1] != '0));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rvalid_o, irq_o, fiq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    prio_intc dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // monitor: compare returned read data against the queue
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
        chk("R1 rvalid", {31'd0, rvalid_o}, 32'd0);
        rd(12'h008, 32'h0, "R1 irq mask");
        rd(12'h108, 32'h0, "R1 fiq mask");
        rd(12'h02C, 32'hF, "R1 irq thr");
        rd(12'h12C, 32'hF, "R1 fiq thr");
        rd(12'h200, 32'hFFFF_FFFF, "R1 polarity");
        rd(12'h204, 32'h0, "R1 sticky");
        rd(12'h314, 32'h0, "R1 prio5");
        rd(12'h020, 32'h0, "R1 cur none");

        // R3 polarity and raw view
        src_i = 32'h1;
        rd(12'h004, 32'h1, "R3 raw pass");
        wr(12'h200, 32'hFFFF_FFFE);
        rd(12'h004, 32'h0, "R3 raw inverted high");
        src_i = 32'h0;
        rd(12'h004, 32'h1, "R3 raw inverted low");
        rd(12'h104, 32'h1, "R3 raw shared fiq");
        wr(12'h200, 32'hFFFF_FFFF);

        // R2 set/clear masks
        wr(12'h008, 32'h0000_00F0);
        rd(12'h008, 32'hF0, "R2 set");
        wr(12'h008, 32'h3);
        rd(12'h008, 32'hF3, "R2 set accumulate");
        wr(12'h00C, 32'h30);
        rd(12'h008, 32'hC3, "R2 clear");
        wr(12'h008, 32'h0);
        rd(12'h008, 32'hC3, "R2 zero set no effect");
        rd(12'h00C, 32'h0, "R2 clear reads zero");
        rd(12'h108, 32'h0, "R10 fiq mask untouched");

        // R5 / R6 / R9
        src_i = 32'h82;
        rd(12'h000, 32'h82, "R5 status");
        rd(12'h020, 32'h1, "R6 tie lowest number");
        chk("R9 irq_o asserted", {31'd0, irq_o}, 32'd1);
        chk("R10 fiq_o idle", {31'd0, fiq_o}, 32'd0);

        // R7 priorities and threshold
        wr(12'h304, 32'h5);
        wr(12'h31C, 32'h3);
        rd(12'h31C, 32'h3, "R7 prio readback");
        rd(12'h020, 32'h7, "R6 lowest value wins");
        wr(12'h02C, 32'h4);
        rd(12'h000, 32'h80, "R7 threshold filters");
        rd(12'h020, 32'h7, "R7 cur under thr");
        wr(12'h02C, 32'h2);
        rd(12'h000, 32'h0, "R7 none eligible");
        rd(12'h020, 32'h0, "R6 none reads zero");
        tick(1);
        chk("R9 irq_o drops", {31'd0, irq_o}, 32'd0);
        wr(12'h02C, 32'hF);

        // R10 fast bank independent
        wr(12'h108, 32'h2);
        rd(12'h100, 32'h2, "R10 fiq status");
        rd(12'h120, 32'h1, "R10 fiq cur");
        rd(12'h020, 32'h7, "R10 irq cur unchanged");
        chk("R10 fiq_o asserted", {31'd0, fiq_o}, 32'd1);

        // R4 / R8 sticky and acknowledge
        src_i = 32'h0;
        wr(12'h204, 32'h10);
        wr(12'h008, 32'h10);
        src_i = 32'h11;
        tick(1);
        src_i = 32'h0;
        rd(12'h004, 32'h10, "R4 sticky held, level follows");
        rd(12'h020, 32'h4, "R4 held source current");
        chk("R9 irq_o from held", {31'd0, irq_o}, 32'd1);
        rd(12'h128, 32'h0, "R8 fiq ack nothing");
        rd(12'h004, 32'h10, "R8 other bank ack no effect");
        rd(12'h028, 32'h4, "R8 ack returns current");
        rd(12'h004, 32'h0, "R8 ack cleared");
        chk("R8 irq_o after ack", {31'd0, irq_o}, 32'd0);

        // R11 read-only writes and unmapped reads
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h008, 32'hD3, "R11 status write ignored");
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h108, 32'h2, "R11 raw write ignored");
        rd(12'h3F0, 32'h0, "R11 unmapped");

        tick(3);
        chk("R11 queue drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule